// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 1M words by 4 bits. The host hands over one access at a time through a valid/ready handshake (address, a write flag and write data). The controller then drives the chip-select, output-enable and write-enable strobes, the 20-bit address and the 4-bit data lines. The data lines use a separate output value and a tristate enable. A read returns the captured word with a one-cycle done pulse. A write also ends with a done pulse.

Every timing limit of the memory is given as a parameter in picoseconds. Package functions turn each limit into a clock count, rounding up and never going below one cycle. A write is controlled by write-enable. Chip-select and the address are held for the setup, pulse and recovery phases, and output-enable stays high for the whole write. After a read, a turnaround gap lets the memory release the bus before the controller may drive it again. A power-down request, taken only when the controller is idle, keeps the memory deselected so that its supply can be lowered. When the request is withdrawn, a prescaled counter waits out the retention recovery time, and then a ready flag rises.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, rsp_done is 0, and req_ready and ret_ready are 1.
- R2: During a write, mem_cs_n is low for exactly SETUP+PULSE+RECOV cycles, mem_we_n is low for exactly PULSE cycles, and mem_oe_n never goes low.
- R3: For a write accepted at clock edge 0, mem_we_n is first low after edge SETUP+1. rsp_done pulses after edge SETUP+PULSE+RECOV+1, and req_ready returns at that same point.
- R4: mem_addr carries the accepted address while mem_cs_n is low, and it changes only while mem_cs_n is high.
- R5: mem_dq_oe is 1 only while mem_cs_n is low and mem_oe_n is high, and mem_dq_out is stable and equal to the write data while mem_we_n is low.
- R6: A read holds mem_cs_n and mem_oe_n low, with mem_we_n high, for READ cycles. It samples mem_dq_in on the last of those cycles, and after edge READ+1 it presents that word on rsp_rdata with a one-cycle rsp_done.
- R7: After a read, req_ready returns only after edge READ+TURN+1. mem_dq_oe never rises sooner than TURN+1 cycles after mem_oe_n rose.
- R8: While req_ready is 0, req_valid and its payload are ignored. rsp_done is never high for two cycles in a row.
- R9: pd_req seen while idle deasserts req_ready and ret_ready and keeps mem_cs_n high for as long as pd_req stays high.
- R10: Once pd_req falls, ret_ready and req_ready rise after exactly RET_US times (cycles per microsecond) cycles, plus one cycle.
- R11: pd_req asserted only while an access is in progress, and withdrawn before that access ends, has no effect: ret_ready stays 1 and the next request is accepted at once.
- R12: Each cycle count is the ceiling of its time divided by CLK_PS, with a minimum of 1. PULSE is also at least as long as the write cycle time minus setup and recovery. READ is one cycle longer than the access time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read data, valid with rsp_done |
| pd_req | input | 1 | Power-down (data retention) request |
| ret_ready | output | 1 | Retention recovery time has elapsed |
| mem_addr | output | 20 | Memory address lines |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 4 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_out |
| mem_dq_in | input | 4 | Data read back from the memory lines |

## Verification
Every strobe and the done pulse come from registers loaded from the next state, so each output changes one edge after the decision that causes it. For a write, write-enable falls SETUP+1 edges after acceptance and done comes SETUP+PULSE+RECOV+1 edges after acceptance. For a read, done comes READ+1 edges after acceptance and ready comes back READ+TURN+1 edges after acceptance. The bench computes these counts itself from the timing parameters. It drives inputs and samples outputs on the falling clock edge, numbers each sample by the rising edges since acceptance, and compares the first and last index of each strobe with the computed counts. Its memory model puts valid data on the bus only after the read window has been open for a full cycle, so a read that samples one cycle early returns wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WPUL, ST_WREC, ST_RACC, ST_RTURN, ST_PDN, ST_RWAIT
  } st_e;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // ceiling of ps / clk_ps, never below one cycle
  function automatic int unsigned ps_to_cyc(int unsigned ps, int unsigned clk_ps);
    int unsigned c;
    c = (ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  // write-enable low time: pulse width, data setup, and the rest of the cycle time
  function automatic int unsigned pulse_cyc(int unsigned wp_ps, int unsigned dw_ps,
                                            int unsigned wc_ps, int unsigned setup,
                                            int unsigned recov, int unsigned clk_ps);
    int c;
    int rest;
    c = int'(ps_to_cyc(wp_ps, clk_ps));
    if (int'(ps_to_cyc(dw_ps, clk_ps)) > c) c = int'(ps_to_cyc(dw_ps, clk_ps));
    rest = int'(ps_to_cyc(wc_ps, clk_ps)) - int'(setup) - int'(recov);
    if (rest > c) c = rest;
    return int'(c);
  endfunction

  // read window: access time plus one cycle for the input sampling path
  function automatic int unsigned read_cyc(int unsigned aa_ps, int unsigned clk_ps);
    return ps_to_cyc(aa_ps, clk_ps) + 1;
  endfunction

  function automatic int unsigned cyc_per_us(int unsigned clk_ps);
    int unsigned c;
    c = 1000000 / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic strobe_t strobes_for(st_e s);
    strobe_t o;
    o = STROBE_IDLE;
    case (s)
      ST_WSET:  begin o.cs_n = 1'b0; o.dq_oe = 1'b1; end
      ST_WPUL:  begin o.cs_n = 1'b0; o.we_n = 1'b0; o.dq_oe = 1'b1; end
      ST_WREC:  begin o.cs_n = 1'b0; o.dq_oe = 1'b1; end
      ST_RACC:  begin o.cs_n = 1'b0; o.oe_n = 1'b0; end
      default:  o = STROBE_IDLE;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned SETUP = 1,
  parameter int unsigned PULSE = 1,
  parameter int unsigned RECOV = 1,
  parameter int unsigned READ  = 2,
  parameter int unsigned TURN  = 1,
  parameter int unsigned CNT_W = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_we,
  input  logic    pd_req,
  input  logic    ret_done,
  output logic    req_ready,
  output logic    accept,
  output logic    rd_capture,
  output logic    wr_end,
  output logic    pd_enter,
  output logic    pd_hold,
  output logic    in_rwait,
  output logic    done,
  output strobe_t strb
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE - 1);
  localparam logic [CNT_W-1:0] LD_RECOV = CNT_W'(RECOV - 1);
  localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(READ - 1);
  localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN - 1);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;
  logic             done_q;
  strobe_t          strb_q;

  assign last      = (cnt_q == '0);
  assign req_ready = (st_q == ST_IDLE) && !pd_req;
  assign accept    = req_valid && req_ready;
  assign rd_capture = (st_q == ST_RACC) && last;
  assign wr_end    = (st_q == ST_WREC) && last;
  assign pd_enter  = (st_q == ST_IDLE) && pd_req;
  assign pd_hold   = (st_q == ST_PDN) || (st_q == ST_RWAIT);
  assign in_rwait  = (st_q == ST_RWAIT);

  always_comb begin
    st_d  = st_q;
    cnt_d = last ? cnt_q : cnt_q - 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (pd_req) begin
          st_d = ST_PDN;
        end else if (req_valid) begin
          if (req_we) begin
            st_d  = ST_WSET;
            cnt_d = LD_SETUP;
          end else begin
            st_d  = ST_RACC;
            cnt_d = LD_READ;
          end
        end
      end
      ST_WSET:  if (last) begin st_d = ST_WPUL;  cnt_d = LD_PULSE; end
      ST_WPUL:  if (last) begin st_d = ST_WREC;  cnt_d = LD_RECOV; end
      ST_WREC:  if (last) st_d = ST_IDLE;
      ST_RACC:  if (last) begin st_d = ST_RTURN; cnt_d = LD_TURN; end
      ST_RTURN: if (last) st_d = ST_IDLE;
      ST_PDN:   if (!pd_req) st_d = ST_RWAIT;
      ST_RWAIT: if (ret_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      strb_q <= STROBE_IDLE;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= rd_capture || wr_end;
      strb_q <= strobes_for(st_d);
    end
  end

  assign done = done_q;
  assign strb = strb_q;

endmodule

// File: rtl/asram_path.sv
module asram_path #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // address and data only load on acceptance, which happens with chip select high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_capture) rdata_q <= mem_dq_in;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/asram_retain.sv
module asram_retain #(
  parameter int unsigned PRE    = 100,
  parameter int unsigned RET_US = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic pd_enter,
  output logic ret_done,
  output logic ret_ready
);

  localparam int unsigned PRE_W = $clog2(PRE + 1);
  localparam int unsigned US_W  = $clog2(RET_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE - 1);
  localparam logic [US_W-1:0]  US_LAST  = US_W'(RET_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;
  logic             tick;
  logic             ready_q;

  assign tick     = active && (pre_q == PRE_LAST);
  assign ret_done = tick && (us_q == US_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (!active) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (tick) begin
      pre_q <= '0;
      us_q  <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b1;
    else if (pd_enter) ready_q <= 1'b0;
    else if (ret_done) ready_q <= 1'b1;
  end

  assign ret_ready = ready_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_AS_PS  = 0,
  parameter int unsigned T_WP_PS  = 7000,
  parameter int unsigned T_DW_PS  = 5000,
  parameter int unsigned T_WR_PS  = 0,
  parameter int unsigned T_WC_PS  = 10000,
  parameter int unsigned T_AA_PS  = 10000,
  parameter int unsigned T_OHZ_PS = 5000,
  parameter int unsigned RET_US   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              pd_req,
  output logic              ret_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned SETUP_CYC = ps_to_cyc(T_AS_PS, CLK_PS);
  localparam int unsigned RECOV_CYC = ps_to_cyc(T_WR_PS, CLK_PS);
  localparam int unsigned PULSE_CYC = pulse_cyc(T_WP_PS, T_DW_PS, T_WC_PS,
                                                SETUP_CYC, RECOV_CYC, CLK_PS);
  localparam int unsigned READ_CYC  = read_cyc(T_AA_PS, CLK_PS);
  localparam int unsigned TURN_CYC  = ps_to_cyc(T_OHZ_PS, CLK_PS);
  localparam int unsigned PRE_CYC   = cyc_per_us(CLK_PS);
  localparam int unsigned MAX_A     = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_B     = (RECOV_CYC > READ_CYC) ? RECOV_CYC : READ_CYC;
  localparam int unsigned MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC   = (MAX_C > TURN_CYC) ? MAX_C : TURN_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  // named internal events
  logic    accept;
  logic    rd_capture;
  logic    wr_end;
  logic    pd_enter;
  logic    pd_hold;
  logic    in_rwait;
  logic    ret_done;
  strobe_t strb;

  asram_seq #(
    .SETUP (SETUP_CYC),
    .PULSE (PULSE_CYC),
    .RECOV (RECOV_CYC),
    .READ  (READ_CYC),
    .TURN  (TURN_CYC),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .pd_req     (pd_req),
    .ret_done   (ret_done),
    .req_ready  (req_ready),
    .accept     (accept),
    .rd_capture (rd_capture),
    .wr_end     (wr_end),
    .pd_enter   (pd_enter),
    .pd_hold    (pd_hold),
    .in_rwait   (in_rwait),
    .done       (rsp_done),
    .strb       (strb)
  );

  asram_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_capture (rd_capture),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_rdata  (rsp_rdata)
  );

  asram_retain #(
    .PRE    (PRE_CYC),
    .RET_US (RET_US)
  ) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (in_rwait),
    .pd_enter  (pd_enter),
    .ret_done  (ret_done),
    .ret_ready (ret_ready)
  );

  assign mem_cs_n  = strb.cs_n;
  assign mem_oe_n  = strb.oe_n;
  assign mem_we_n  = strb.we_n;
  assign mem_dq_oe = strb.dq_oe;

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rsp_done,
  input logic              req_ready,
  input logic              pd_hold
);

  logic [7:0] oe_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_hi_q <= 8'hff;
    else if (!mem_oe_n) oe_hi_q <= '0;
    else if (oe_hi_q != 8'hff) oe_hi_q <= oe_hi_q + 1'b1;
  end

  a_r2_write_keeps_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n));

  a_r6_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  a_r5_drive_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_q >= 8'd1));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_dq_oe));

  a_r9_pd_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    pd_hold |-> (mem_cs_n && !req_ready));

endmodule

bind asram_ctrl asram_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_dq_out (mem_dq_out),
  .mem_addr   (mem_addr),
  .rsp_done   (rsp_done),
  .req_ready  (req_ready),
  .pd_hold    (pd_hold)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int CLK   = 10000;
  localparam int AS    = 0;
  localparam int WP    = 7000;
  localparam int DW    = 5000;
  localparam int WR    = 0;
  localparam int WC    = 10000;
  localparam int AA    = 10000;
  localparam int OHZ   = 5000;
  localparam int RETUS = 3;

  // bench restatement of R12: whole cycles covering a time, at least one
  function automatic int cover_cyc(int ps);
    int n;
    n = 0;
    while (n * CLK < ps) n++;
    return (n == 0) ? 1 : n;
  endfunction

  localparam int E_S  = cover_cyc(AS);
  localparam int E_R  = cover_cyc(WR);
  localparam int E_P0 = (cover_cyc(WP) > cover_cyc(DW)) ? cover_cyc(WP) : cover_cyc(DW);
  localparam int E_P  = (cover_cyc(WC) - E_S - E_R > E_P0) ? cover_cyc(WC) - E_S - E_R : E_P0;
  localparam int E_RD = cover_cyc(AA) + 1;
  localparam int E_T  = cover_cyc(OHZ);
  localparam int E_RET = RETUS * (1000000 / CLK);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        rsp_done;
  logic [3:0]  rsp_rdata;
  logic        pd_req = 1'b0;
  logic        ret_ready;
  logic [19:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [3:0]  mem_dq_out;
  logic [3:0]  mem_dq_in;

  always #5 clk = ~clk;

  asram_ctrl #(.RET_US(RETUS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .pd_req(pd_req),
    .ret_ready(ret_ready), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // memory model: data valid only after the read window has been open a full cycle
  logic [3:0] mem [256];
  logic [1:0] rd_age;
  logic       rd_open;
  assign rd_open   = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = (rd_open && rd_age != 2'd0) ? mem[mem_addr[7:0]] : ~mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (rd_open) rd_age <= (rd_age == 2'd3) ? rd_age : rd_age + 2'd1;
    else rd_age <= 2'd0;
  end

  always @(posedge mem_we_n) begin
    if (mem_cs_n === 1'b0 && mem_dq_oe === 1'b1) mem[mem_addr[7:0]] <= mem_dq_out;
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // continuous monitors sampled on the falling edge
  int contention = 0, turn_bad = 0, addr_bad = 0, oe_hi = 100;
  logic prev_cs_n = 1'b1, prev_dq_oe = 1'b0;
  logic [19:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) contention++;
      if (mem_dq_oe && !prev_dq_oe && oe_hi < E_T + 1) turn_bad++;
      if (!mem_cs_n && !prev_cs_n && mem_addr != prev_addr) addr_bad++;
      oe_hi = mem_oe_n ? oe_hi + 1 : 0;
      prev_cs_n = mem_cs_n;
      prev_dq_oe = mem_dq_oe;
      prev_addr = mem_addr;
    end
  end

  // results of the last access
  int k_we, n_we, n_cs, n_oe, k_done, n_done, k_ready, rd_val;
  bit addr_ok, data_ok;

  // issue one access; junk=1 keeps a different request valid while busy;
  // pdb=1 raises pd_req while an access is in flight
  task automatic access(input bit we, input logic [19:0] a, input logic [3:0] d,
                        input bit junk, input bit pdb);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    k_we = 0; n_we = 0; n_cs = 0; n_oe = 0; k_done = 0; n_done = 0; k_ready = 0;
    rd_val = -1; addr_ok = 1; data_ok = 1;
    for (int k = 1; k <= 40 && k_ready == 0; k++) begin
      @(negedge clk);
      if (!mem_we_n) begin
        if (k_we == 0) k_we = k;
        n_we++;
        if (mem_dq_out != d) data_ok = 0;
      end
      if (!mem_cs_n) begin
        n_cs++;
        if (mem_addr != a) addr_ok = 0;
      end
      if (!mem_oe_n) n_oe++;
      if (rsp_done) begin
        n_done++;
        if (k_done == 0) begin k_done = k; rd_val = rsp_rdata; end
      end
      if (req_ready && k_ready == 0) k_ready = k;
      if (junk && !req_ready) begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = a ^ 20'h00001; req_wdata = ~d;
      end else begin
        req_valid = 1'b0;
      end
      pd_req = pdb && !mem_cs_n;
    end
    req_valid = 1'b0;
    pd_req = 1'b0;
  endtask

  task automatic t_reset;
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
    check(!mem_dq_oe, "R1 bus released", mem_dq_oe, 0);
    check(!rsp_done, "R1 no done", rsp_done, 0);
    check(req_ready && ret_ready, "R1 ready flags", {req_ready, ret_ready}, 3);
  endtask

  task automatic t_write(input logic [19:0] a, input logic [3:0] d);
    access(1'b1, a, d, 1'b0, 1'b0);
    check(k_we == E_S + 1, "R3 we falls", k_we, E_S + 1);
    check(n_we == E_P, "R2 R12 we low cycles", n_we, E_P);
    check(n_cs == E_S + E_P + E_R, "R2 cs low cycles", n_cs, E_S + E_P + E_R);
    check(n_oe == 0, "R2 oe stays high", n_oe, 0);
    check(k_done == E_S + E_P + E_R + 1, "R3 done timing", k_done, E_S + E_P + E_R + 1);
    check(k_ready == E_S + E_P + E_R + 1, "R3 ready return", k_ready, E_S + E_P + E_R + 1);
    check(addr_ok, "R4 address on bus", addr_ok, 1);
    check(data_ok, "R5 write data on bus", data_ok, 1);
  endtask

  task automatic t_read(input logic [19:0] a, input logic [3:0] exp);
    access(1'b0, a, 4'h0, 1'b0, 1'b0);
    check(n_oe == E_RD, "R6 R12 read window", n_oe, E_RD);
    check(n_we == 0, "R6 we stays high", n_we, 0);
    check(k_done == E_RD + 1, "R6 done timing", k_done, E_RD + 1);
    check(rd_val == int'(exp), "R6 read data", rd_val, exp);
    check(n_done == 1, "R8 single done", n_done, 1);
    check(k_ready == E_RD + E_T + 1, "R7 turnaround ready", k_ready, E_RD + E_T + 1);
    check(addr_ok, "R4 read address", addr_ok, 1);
  endtask

  task automatic t_ignore;
    t_write(20'h00040, 4'h6);
    t_write(20'h00041, 4'h9);
    access(1'b1, 20'h00040, 4'h3, 1'b1, 1'b0);
    check(k_ready == E_S + E_P + E_R + 1, "R8 busy ready", k_ready, E_S + E_P + E_R + 1);
    t_read(20'h00041, 4'h9);
    t_read(20'h00040, 4'h3);
  endtask

  task automatic t_pd_busy;
    access(1'b1, 20'h00077, 4'h5, 1'b0, 1'b1);
    @(negedge clk);
    check(ret_ready == 1'b1, "R11 retention flag kept", ret_ready, 1);
    check(req_ready == 1'b1, "R11 ready kept", req_ready, 1);
    t_read(20'h00077, 4'h5);
  endtask

  task automatic t_pd;
    int j;
    bit cs_ok;
    @(negedge clk);
    pd_req = 1'b1;
    cs_ok = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!mem_cs_n || req_ready || ret_ready) cs_ok = 0;
      req_valid = 1'b1; req_we = 1'b1; req_addr = 20'h00077; req_wdata = 4'hE;
    end
    check(cs_ok, "R9 deselect while pd", cs_ok, 1);
    req_valid = 1'b0;
    pd_req = 1'b0;
    j = 0;
    while (!ret_ready && j < E_RET + 20) begin
      @(negedge clk);
      j++;
      if (!mem_cs_n) cs_ok = 0;
    end
    check(j == E_RET + 1, "R10 retention wait", j, E_RET + 1);
    check(req_ready == 1'b1, "R10 ready after wait", req_ready, 1);
    check(cs_ok, "R9 deselect through wait", cs_ok, 1);
    t_read(20'h00077, 4'h5);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    rd_age = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(20'hA5312, 4'hA);
    t_read(20'hA5312, 4'hA);
    t_write(20'h0FF20, 4'h1);
    t_write(20'h0FF21, 4'hF);
    t_read(20'h0FF20, 4'h1);
    t_read(20'h0FF21, 4'hF);
    t_ignore();
    t_pd_busy();
    t_pd();
    check(contention == 0, "R5 no drive against memory", contention, 0);
    check(turn_bad == 0, "R7 drive after turnaround", turn_bad, 0);
    check(addr_bad == 0, "R4 address steady under select", addr_bad, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule